// File: doc/BRIEF.md
# LIN Bus Remote Wake-Up Detector

This block watches a LIN bus for remote wake-up activity while the transceiver sits in its deepest low-power state. Its data input comes from a comparator that uses a dedicated wake threshold (around 3.4 V) instead of the normal receive threshold. That input is high while the bus is above the threshold (recessive side) and low while the bus is pulled below it (dominant side). An enable input is driven high only while the transceiver is powered down. A free-running tick input supplies the time base.

A wake-up qualifies only if a dominant phase lasts at least a minimum width, about 80 µs in the target system. The width is counted in tick periods. Even then, the block does not react to the dominant level itself. It issues a single-clock wake pulse only when the bus is released back to recessive. The power controller uses that pulse to move from power-down to the ready state.

Shorter dominant phases are discarded, and each new dominant phase is measured from zero. Removing the enable clears all internal state.

Top module: `lin_wake_detect`

## Requirements
- R1: After reset, and while the bus stays recessive, `wake_o` is 0.
- R2: A dominant phase that lasts fewer than `MIN_TICKS` tick-qualified clock cycles, followed by release, produces no wake pulse.
- R3: A dominant phase that lasts at least `MIN_TICKS` tick-qualified clock cycles, followed by release, produces exactly one wake pulse. If `bus_cmp_i` rises before clock edge k, `wake_o` is high between edges k+2 and k+3 (default two synchronizer stages).
- R4: No wake pulse is issued while the bus is still dominant, however long the dominant phase lasts.
- R5: Every wake pulse is exactly one clock cycle wide.
- R6: While `enable` is 0, no wake pulse is issued and the accumulated width is discarded. A dominant level that is already present when `enable` rises is measured from the moment `enable` rises.
- R7: Width is measured only in clock cycles where `tick` is 1. A dominant phase with no ticks never qualifies.
- R8: The width counter saturates at `MIN_TICKS`. A very long dominant phase still yields exactly one pulse on release.
- R9: Any recessive level restarts the measurement. Two short dominant phases separated by a recessive gap do not add up.
- R10: If `enable` falls in the same cycle that the synchronized rising edge is detected, no wake pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | High only in power-down; low clears all state |
| tick | input | 1 | Time-base strobe; one width unit per high cycle |
| bus_cmp_i | input | 1 | Wake comparator output, 1 = above threshold (recessive), 0 = dominant |
| wake_o | output | 1 | One-cycle wake request |

## Verification
Two events can fall in the same cycle: the synchronized rising edge that should fire a wake, and the deassertion of `enable` that must clear the detector. The bench builds a qualified dominant phase and releases the bus. It then drops `enable` exactly in the cycle where the rise reaches the edge detector, two clocks after the release. It judges the outcome by confirming that `wake_o` stays low in the cycle where it would otherwise have fired, and that no pulse is counted afterwards. A second coincidence is a tick that arrives in the cycle of the rise. This is covered by the boundary runs with a continuous tick, where a phase of exactly `MIN_TICKS` cycles must fire and one cycle less must not.

// File: rtl/lwd_pkg.sv
package lwd_pkg;
   // Width needed to hold values 0..max_val
   function automatic int cnt_bits(input int max_val);
      return (max_val < 1) ? 1 : $clog2(max_val + 1);
   endfunction

   localparam logic LVL_RECESSIVE = 1'b1;
endpackage

// File: rtl/lwd_sync.sv
module lwd_sync #(
   parameter int   STAGES  = 2,
   parameter logic INIT    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   chain[0] <= INIT;
               else if (clr) chain[0] <= INIT;
               else          chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   chain[i] <= INIT;
               else if (clr) chain[i] <= INIT;
               else          chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/lwd_width_qual.sv
module lwd_width_qual #(
   parameter int MIN_TICKS = 8,
   parameter int CNT_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             lvl,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic             qualified
);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MIN_TICKS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (clr)                cnt <= '0;
      else if (lvl == lwd_pkg::LVL_RECESSIVE) cnt <= '0;
      else if (tick && cnt != LIMIT) cnt <= cnt + 1'b1;
   end

   assign qualified = (cnt == LIMIT);
endmodule

// File: rtl/lwd_edge_fire.sv
module lwd_edge_fire (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic lvl,
   input  logic qualified,
   output logic wake
);
   logic prev_lvl;
   logic rise;

   assign rise = lvl & ~prev_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_lvl <= lwd_pkg::LVL_RECESSIVE;
         wake     <= 1'b0;
      end else if (clr) begin
         prev_lvl <= lwd_pkg::LVL_RECESSIVE;
         wake     <= 1'b0;
      end else begin
         prev_lvl <= lvl;
         wake     <= rise & qualified;
      end
   end
endmodule

// File: rtl/lin_wake_detect.sv
module lin_wake_detect #(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_TICKS   = 8,
   localparam int CNT_W      = lwd_pkg::cnt_bits(MIN_TICKS)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic tick,
   input  logic bus_cmp_i,
   output logic wake_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         initial $error("SYNC_STAGES must be at least 2");
      end
      if (MIN_TICKS < 1) begin : g_bad_min
         initial $error("MIN_TICKS must be at least 1");
      end
   endgenerate

   logic             clr;
   logic             bus_lvl;
   logic [CNT_W-1:0] dom_cnt;
   logic             dom_ok;

   assign clr = ~enable;

   lwd_sync #(.STAGES(SYNC_STAGES), .INIT(lwd_pkg::LVL_RECESSIVE)) u_sync (
      .clk(clk), .rst_n(rst_n), .clr(clr), .d(bus_cmp_i), .q(bus_lvl)
   );

   lwd_width_qual #(.MIN_TICKS(MIN_TICKS), .CNT_W(CNT_W)) u_qual (
      .clk(clk), .rst_n(rst_n), .clr(clr), .lvl(bus_lvl), .tick(tick),
      .cnt(dom_cnt), .qualified(dom_ok)
   );

   lwd_edge_fire u_fire (
      .clk(clk), .rst_n(rst_n), .clr(clr), .lvl(bus_lvl),
      .qualified(dom_ok), .wake(wake_o)
   );
endmodule

// File: rtl/lwd_chk.sv
module lwd_chk #(
   parameter int MIN_TICKS = 8,
   parameter int CNT_W     = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic             tick,
   input logic             lvl,
   input logic [CNT_W-1:0] cnt,
   input logic             wake
);
   // R5
   wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake |=> !wake);
   // R6
   wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !wake);
   // R6
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (cnt == '0));
   // R9
   cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && lvl) |=> (cnt == '0));
   // R7
   no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !tick && !lvl) |=> $stable(cnt));
   // R3
   wake_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> ($past(cnt) == CNT_W'(MIN_TICKS)));
   // R4
   wake_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> ($past(lvl) && $past(enable)));
   // R8
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(MIN_TICKS));
endmodule

bind lin_wake_detect lwd_chk #(.MIN_TICKS(MIN_TICKS), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
   .lvl(bus_lvl), .cnt(dom_cnt), .wake(wake_o)
);

// File: tb/lin_wake_detect_tb.sv
module lin_wake_detect_tb;
   localparam int MINT = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0;
   logic bus = 1'b1;
   logic tick;
   logic wake_o;

   int tick_mode = 1;   // 0 none, 1 every cycle, 2 every 4th cycle
   int div = 0;
   int checks = 0;
   int errors = 0;
   int pulses = 0;
   int wide = 0;
   logic last_wake = 1'b0;

   always #10 clk = ~clk;

   assign tick = (tick_mode == 1) ? 1'b1 : (tick_mode == 2) ? (div == 0) : 1'b0;

   lin_wake_detect #(.SYNC_STAGES(2), .MIN_TICKS(MINT)) u_dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
      .bus_cmp_i(bus), .wake_o(wake_o)
   );

   always @(negedge clk) begin
      div <= (div + 1) % 4;
      if (wake_o) pulses <= pulses + 1;
      if (wake_o && last_wake) wide <= wide + 1;
      last_wake <= wake_o;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_dom(input int len, input int expect_n, input string tag);
      int base;
      base = pulses;
      bus = 1'b0;
      cyc(len);
      bus = 1'b1;
      cyc(8);
      chk(pulses - base == expect_n, tag, pulses - base, expect_n);
   endtask

   task automatic t_reset();
      cyc(2);
      chk(wake_o == 1'b0, "R1 in reset", int'(wake_o), 0);
      rst_n = 1'b1;
      enable = 1'b1;
      cyc(10);
      chk(pulses == 0, "R1 idle after reset", pulses, 0);
   endtask

   task automatic t_boundary();
      tick_mode = 1;
      pulse_dom(MINT - 1, 0, "R2 one below minimum");
      pulse_dom(MINT, 1, "R3 exactly minimum");
   endtask

   task automatic t_latency();
      bus = 1'b0;
      cyc(MINT + 2);
      bus = 1'b1;
      cyc(1); chk(wake_o == 1'b0, "R3 latency c1", int'(wake_o), 0);
      cyc(1); chk(wake_o == 1'b0, "R3 latency c2", int'(wake_o), 0);
      cyc(1); chk(wake_o == 1'b1, "R3 latency c3", int'(wake_o), 1);
      cyc(1); chk(wake_o == 1'b0, "R5 pulse ends", int'(wake_o), 0);
      cyc(5);
   endtask

   task automatic t_long();
      int base;
      base = pulses;
      bus = 1'b0;
      cyc(200);
      chk(pulses == base, "R4 no wake while dominant", pulses - base, 0);
      bus = 1'b1;
      cyc(8);
      chk(pulses - base == 1, "R8 saturated single wake", pulses - base, 1);
   endtask

   task automatic t_ticks();
      tick_mode = 0;
      pulse_dom(50, 0, "R7 no ticks");
      tick_mode = 2;
      pulse_dom(16, 0, "R7 slow ticks short");
      pulse_dom(60, 1, "R7 slow ticks long");
      tick_mode = 1;
   endtask

   task automatic t_split();
      int base;
      base = pulses;
      bus = 1'b0; cyc(6);
      bus = 1'b1; cyc(2);
      bus = 1'b0; cyc(6);
      bus = 1'b1; cyc(8);
      chk(pulses == base, "R9 split phases", pulses - base, 0);
   endtask

   task automatic t_enable();
      int base;
      enable = 1'b0;
      pulse_dom(30, 0, "R6 disabled");
      enable = 1'b1;
      base = pulses;
      bus = 1'b0; cyc(5);
      enable = 1'b0; cyc(2);
      enable = 1'b1; cyc(5);
      bus = 1'b1; cyc(8);
      chk(pulses == base, "R6 width discarded", pulses - base, 0);
      enable = 1'b0;
      bus = 1'b0; cyc(3);
      enable = 1'b1;
      cyc(20);
      base = pulses;
      bus = 1'b1; cyc(8);
      chk(pulses - base == 1, "R6 dominant at enable", pulses - base, 1);
   endtask

   task automatic t_same_cycle();
      int base;
      base = pulses;
      bus = 1'b0; cyc(20);
      bus = 1'b1; cyc(2);
      enable = 1'b0;
      cyc(1);
      chk(wake_o == 1'b0, "R10 wake suppressed", int'(wake_o), 0);
      cyc(5);
      enable = 1'b1;
      cyc(5);
      chk(pulses == base, "R10 no pulse counted", pulses - base, 0);
   endtask

   initial begin
      t_reset();
      t_boundary();
      t_latency();
      t_long();
      t_ticks();
      t_split();
      t_enable();
      t_same_cycle();
      chk(wide == 0, "R5 no wide pulse", wide, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule